// File: doc/BRIEF.md
# Handshaked Module Clock-Halt Controller

This block lets software stop the clocks of a group of peripheral channels and of one processor channel without ever cutting a clock under a module that is still busy. Software writes a halt register that holds one bit per channel. A set bit raises that channel's stop request. The channel's clock enable is withdrawn only once the module answers with its stop acknowledge, which it gives after a clean shutdown. The acknowledge lines are also visible in a read-only status register.

When software clears a halt bit, the clock enable comes back first. The stop request stays high for a fixed settle time while the clock runs, and is then released. If the bit is cleared before any acknowledge arrives, the request is withdrawn and the clock is never gated. The processor channel is guarded against accidental halting: its request is issued only while the processor reports that it is waiting. Clock gating is represented by enable outputs that feed the chip's real gating cells.

Top module: `clk_halt_ctrl`

## Requirements
- R1: After a synchronous reset every halt bit reads 0, every stop_req bit is 0 and every clk_en bit is 1.
- R2: A bus write (bus_valid=1, bus_write=1) to offset 0 loads the halt register from bus_wdata bit i for channel i. A bus read of offset 0 returns that register in bus_rdata on the cycle after the read.
- R3: While the halt bit of a peripheral channel is 1 and no acknowledge has arrived, that channel's stop_req is 1 and its clk_en stays 1.
- R4: A channel's clk_en goes to 0 only in the cycle after its stop_ack was seen high while it was requesting.
- R5: A bus read of offset 4 returns the stop_ack lines, bit i for channel i, as sampled one cycle earlier. Bus writes to offset 4 change no register and no output.
- R6: When the halt bit of a gated channel is cleared, clk_en returns to 1 first. stop_req then stays 1, with clk_en at 1, for exactly SETTLE cycles (default 4) before it falls.
- R7: If the halt bit is cleared while a channel is requesting and no acknowledge has arrived, stop_req falls and clk_en never leaves 1.
- R8: The processor channel is bit N_PERIPH, the highest bit. Its stop_req rises only when its halt bit is 1 and cpu_wait was 1 in the previous cycle. With cpu_wait at 0, a set halt bit leaves it running.
- R9: A channel's clk_en is never 0 unless its stop_req is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset (0 = halt, 4 = acknowledge status) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| cpu_wait | input | 1 | Processor reports wait state |
| stop_ack | input | N_PERIPH+1 | Per-channel clean-shutdown acknowledge |
| stop_req | output | N_PERIPH+1 | Per-channel stop request |
| clk_en | output | N_PERIPH+1 | Per-channel clock enable |

## Verification
The assertions check the handshake ordering on every cycle. They confirm that no enable falls without a prior acknowledge, that no gated channel lacks a request, that a request after gating drops only after the full settle time with the clock running, that the processor request rises only under a wait state, and that the status register tracks the acknowledges. The bench scenarios are the only way to show the register contents and their read-back. They also show that a write to the status offset does nothing, that an early clear aborts cleanly without gating, and that the settle time is exactly four cycles and not more.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [1:0] {
    CH_RUN   = 2'd0,
    CH_REQ   = 2'd1,
    CH_GATED = 2'd2,
    CH_WAKE  = 2'd3
  } ch_state_e;
endpackage

// File: rtl/chg_regs.sv
module chg_regs #(
  parameter int NCH    = 5,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NCH-1:0]    stop_ack,
  output logic [NCH-1:0]    halt_q,
  output logic [NCH-1:0]    ack_q,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] OFF_HALT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_ACK  = ADDR_W'(4);

  logic wr_halt, rd_any;
  assign wr_halt = bus_valid && bus_write && (bus_addr == OFF_HALT);
  assign rd_any  = bus_valid && !bus_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q    <= '0;
      ack_q     <= '0;
      bus_rdata <= '0;
    end else begin
      ack_q <= stop_ack;
      if (wr_halt) halt_q <= bus_wdata[NCH-1:0];
      if (rd_any) begin
        if (bus_addr == OFF_HALT)     bus_rdata <= DATA_W'(halt_q);
        else if (bus_addr == OFF_ACK) bus_rdata <= DATA_W'(ack_q);
        else                          bus_rdata <= '0;
      end
    end
  end

  // R5: status mirrors the acknowledge lines one cycle late
  p_ack_mirror_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ack_q == $past(stop_ack)));
endmodule

// File: rtl/chg_chan.sv
module chg_chan
  import chg_pkg::*;
#(
  parameter int SETTLE = 4,
  parameter bit IS_CPU = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic halt_i,
  input  logic wait_i,
  input  logic ack_i,
  output logic req_o,
  output logic en_o
);
  localparam int CNT_W = (SETTLE < 2) ? 1 : $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1);

  ch_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic             start;

  generate
    if (IS_CPU) begin : g_cpu
      assign start = halt_i && wait_i;
    end else begin : g_per
      assign start = halt_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= CH_RUN;
      cnt <= '0;
    end else begin
      case (st)
        CH_RUN:   if (start) st <= CH_REQ;
        CH_REQ: begin
          if (!halt_i)    st <= CH_RUN;
          else if (ack_i) st <= CH_GATED;
        end
        CH_GATED: if (!halt_i) begin
          st  <= CH_WAKE;
          cnt <= '0;
        end
        CH_WAKE: begin
          if (cnt == LAST) st <= CH_RUN;
          else             cnt <= cnt + 1'b1;
        end
        default: st <= CH_RUN;
      endcase
    end
  end

  assign req_o = (st != CH_RUN);
  assign en_o  = (st != CH_GATED);

  // checker state: cycles with clock on and request held since last gating
  logic             gated_seen;
  logic [CNT_W-1:0] on_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      gated_seen <= 1'b0;
      on_cnt     <= '0;
    end else if (!en_o) begin
      gated_seen <= 1'b1;
      on_cnt     <= '0;
    end else if (!req_o) begin
      gated_seen <= 1'b0;
      on_cnt     <= '0;
    end else if (on_cnt < CNT_W'(SETTLE)) begin
      on_cnt <= on_cnt + 1'b1;
    end
  end

  p_gate_after_ack_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(en_o) |-> $past(ack_i));
  p_gated_has_req_r9: assert property (@(posedge clk) disable iff (rst)
    !en_o |-> req_o);
  p_clock_first_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(req_o) |-> $past(en_o));
  p_settle_len_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(req_o) && gated_seen) |-> (on_cnt >= CNT_W'(SETTLE)));
endmodule

// File: rtl/clk_halt_ctrl.sv
module clk_halt_ctrl #(
  parameter int N_PERIPH = 4,
  parameter int SETTLE   = 4,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                cpu_wait,
  input  logic [N_PERIPH:0]   stop_ack,
  output logic [N_PERIPH:0]   stop_req,
  output logic [N_PERIPH:0]   clk_en
);
  localparam int NCH     = N_PERIPH + 1;
  localparam int CPU_IDX = N_PERIPH;

  logic [NCH-1:0] halt_q;
  logic [NCH-1:0] ack_q;

  chg_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .stop_ack(stop_ack), .halt_q(halt_q), .ack_q(ack_q),
    .bus_rdata(bus_rdata)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      chg_chan #(.SETTLE(SETTLE), .IS_CPU(g == CPU_IDX)) u_ch (
        .clk(clk), .rst(rst),
        .halt_i(halt_q[g]), .wait_i(cpu_wait), .ack_i(stop_ack[g]),
        .req_o(stop_req[g]), .en_o(clk_en[g])
      );
    end
  endgenerate

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (stop_req == '0 && clk_en == '1));
  p_cpu_wait_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_req[CPU_IDX]) |-> $past(cpu_wait));
endmodule

// File: tb/sim_clk_halt_ctrl.sv
`timescale 1ns/1ps
module sim_clk_halt_ctrl;
  localparam int NP = 4;
  localparam int NC = NP + 1;
  localparam int ST = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_wait = 1'b0;
  logic [NC-1:0] stop_ack = '0;
  logic [NC-1:0] stop_req, clk_en;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  clk_halt_ctrl #(.N_PERIPH(NP), .SETTLE(ST)) u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_wait(cpu_wait), .stop_ack(stop_ack), .stop_req(stop_req), .clk_en(clk_en)
  );

  // {halt, ack, wait, exp_req, exp_en}; bit 4 is the processor channel
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {5'b00000, 5'b00000, 1'b0, 5'b00000, 5'b11111},
    {5'b00011, 5'b00000, 1'b0, 5'b00011, 5'b11111},
    {5'b00011, 5'b00001, 1'b0, 5'b00011, 5'b11110},
    {5'b00011, 5'b00011, 1'b0, 5'b00011, 5'b11100},
    {5'b00001, 5'b00011, 1'b0, 5'b00001, 5'b11110},
    {5'b10000, 5'b00000, 1'b0, 5'b00000, 5'b11111},
    {5'b10000, 5'b00000, 1'b1, 5'b10000, 5'b11111},
    {5'b10000, 5'b10000, 1'b1, 5'b10000, 5'b01111},
    {5'b00100, 5'b10000, 1'b0, 5'b00100, 5'b11111},
    {5'b00000, 5'b00000, 1'b0, 5'b00000, 5'b11111}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int on_cycles;
    logic ever_low;

    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 stop_req", 32'(stop_req), 32'h0);
    check("R1 clk_en", 32'(clk_en), 32'h1F);
    bus_rd(4'd0, rd);
    check("R1 halt reg", rd, 32'h0);

    // vector table: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      stop_ack = VEC[v][15:11];
      cpu_wait = VEC[v][10];
      bus_wr(4'd0, 32'(VEC[v][20:16]));
      idle(10);
      check($sformatf("R3/R4/R8 vec%0d stop_req", v), 32'(stop_req), 32'(VEC[v][9:5]));
      check($sformatf("R4/R6/R9 vec%0d clk_en", v), 32'(clk_en), 32'(VEC[v][4:0]));
      bus_rd(4'd4, rd);
      check($sformatf("R5 vec%0d ack status", v), rd, 32'(VEC[v][15:11]));
      bus_rd(4'd0, rd);
      check($sformatf("R2 vec%0d halt readback", v), rd, 32'(VEC[v][20:16]));
    end

    // R6 exact settle length on channel 2
    stop_ack = 5'b00100;
    bus_wr(4'd0, 32'h4);
    idle(6);
    check("R6 gated before wake", 32'(clk_en[2]), 32'h0);
    bus_wr(4'd0, 32'h0);
    on_cycles = 0;
    for (int i = 0; i < 20; i++) begin
      if (clk_en[2] && stop_req[2]) on_cycles++;
      @(negedge clk);
    end
    check("R6 settle cycles", 32'(on_cycles), 32'(ST));
    check("R6 released", 32'(stop_req[2]), 32'h0);
    stop_ack = '0;

    // R7 abort before acknowledge on channel 3
    ever_low = 1'b0;
    bus_wr(4'd0, 32'h8);
    for (int i = 0; i < 4; i++) begin
      if (!clk_en[3]) ever_low = 1'b1;
      @(negedge clk);
    end
    check("R7 request up", 32'(stop_req[3]), 32'h1);
    bus_wr(4'd0, 32'h0);
    for (int i = 0; i < 8; i++) begin
      if (!clk_en[3]) ever_low = 1'b1;
      @(negedge clk);
    end
    check("R7 clock never gated", 32'(ever_low), 32'h0);
    check("R7 request dropped", 32'(stop_req[3]), 32'h0);

    // R5 writes to status offset ignored
    bus_wr(4'd4, 32'h1F);
    idle(4);
    bus_rd(4'd0, rd);
    check("R5 halt after status write", rd, 32'h0);
    check("R5 outputs after status write", 32'(stop_req), 32'h0);
    bus_rd(4'd4, rd);
    check("R5 status after status write", rd, 32'h0);

    // R8 cpu wait dropped then raised while halt bit set
    bus_wr(4'd0, 32'h10);
    idle(5);
    check("R8 no wait no request", 32'(stop_req[4]), 32'h0);
    cpu_wait = 1'b1;
    idle(3);
    check("R8 wait raises request", 32'(stop_req[4]), 32'h1);
    check("R8 clock still on", 32'(clk_en[4]), 32'h1);
    bus_wr(4'd0, 32'h0);
    cpu_wait = 1'b0;
    idle(4);
    check("R8 request cleared", 32'(stop_req[4]), 32'h0);

    // R1 reset mid-operation
    stop_ack = 5'b00001;
    bus_wr(4'd0, 32'h1);
    idle(5);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    stop_ack = '0;
    @(negedge clk);
    check("R1 reset req", 32'(stop_req), 32'h0);
    check("R1 reset en", 32'(clk_en), 32'h1F);
    bus_rd(4'd0, rd);
    check("R1 reset halt", rd, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule